// File: doc/BRIEF.md
# Exception Deactivation Vector Selector

This block retires an exception in an interrupt controller. The controller holds one active bit per exception number. Banked exceptions also have a second, secure copy. When a completion request arrives with an exception number and a secure flag, the block picks the active bit to clear and clears it. It then reports whether the return was legal, whether it failed, and whether the core has gone back to base level, meaning nothing is active any more.

In the newer-architecture mode, a negative raw execution priority overrides the number that was asked for. The block then clears the hard-fault or non-maskable vector that matches that priority. This keeps a core from being stranded at negative priority after a return with a corrupted number. A non-banked exception whose configured target security differs from the request's flag is flagged as an illegal return, but the chosen vector is still deactivated. A separate activation strobe sets active bits, so the surrounding controller (or a bench) can build up state. Every result is registered one clock after the request.

Top module: `exc_deact_top`

## Requirements
- R1: After reset, every active and pending bit in both banks is 0, and `cmp_done`, `cmp_fail`, `cmp_illegal` and `cmp_rettobase` are 0.
- R2: A request sampled with `cmp_req` high at a rising edge produces its result at that same edge, and `cmp_done` is high for exactly that one cycle. `cmp_done` is low after any edge at which `cmp_req` was low.
- R3: A request whose number is 0, 1 or at least `NUM_EXC` reports `cmp_fail`=1 and changes no active or pending bit.
- R4: With `v8_mode`=0, the requested number is the one deactivated at every priority. The secure copy is used only when `cmp_sec`=1 and the number's bit in `BANKED` is set; otherwise the non-secure copy is used.
- R5: With `v8_mode`=1 and `exec_prio`=-1, vector 3 (hard fault) is deactivated. The non-secure copy is used when `fault_ns`=1, and the secure copy when `fault_ns`=0.
- R6: With `v8_mode`=1 and `exec_prio`=-2, the non-secure copy of vector 2 (non-maskable) is deactivated.
- R7: With `v8_mode`=1 and `exec_prio`=-3, the secure copy of vector 3 is deactivated.
- R8: With `v8_mode`=1 and any other priority, the selection follows R4.
- R9: If the selected copy is not active, `cmp_fail`=1, `cmp_illegal`=0 and no bit changes.
- R10: If the requested number is not banked and its `tgt_sec` bit differs from `cmp_sec`, `cmp_illegal`=1 and `cmp_fail`=0. The selected copy is still cleared.
- R11: When a copy is cleared and both its number's `lvl_cfg` bit and its `line_in` bit are 1, the pending bit of that same copy becomes 1.
- R12: After a successful deactivation, `cmp_rettobase`=1 exactly when no active bit remains set in either bank.
- R13: An activation strobe with a valid number sets the active bit of the chosen copy (the same bank rule as R4) and clears its pending bit. The strobe is ignored in any cycle in which `cmp_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_req | input | 1 | Activation strobe |
| act_num | input | EXC_W | Exception number to activate |
| act_sec | input | 1 | Activate the secure copy when the number is banked |
| cmp_req | input | 1 | Completion request strobe |
| cmp_num | input | EXC_W | Exception number to complete |
| cmp_sec | input | 1 | Security state of the completion |
| exec_prio | input | PRIO_W | Raw execution priority, two's complement |
| v8_mode | input | 1 | Enable the newer-architecture forced deactivation |
| fault_ns | input | 1 | Fault escalation target is non-secure |
| tgt_sec | input | NUM_EXC | Per-exception configured target security |
| lvl_cfg | input | NUM_EXC | Per-exception level-sensitive flag |
| line_in | input | NUM_EXC | Per-exception input line state |
| cmp_done | output | 1 | Result valid |
| cmp_sel_num | output | EXC_W | Number of the copy selected for clearing |
| cmp_sel_sec | output | 1 | Selected copy is the secure one |
| cmp_fail | output | 1 | Invalid number or selected copy not active |
| cmp_illegal | output | 1 | Security-state mismatch; deactivation still done |
| cmp_rettobase | output | 1 | No exception active after the update |
| act_ns_o | output | NUM_EXC | Non-secure active bits |
| act_s_o | output | NUM_EXC | Secure active bits |
| pend_ns_o | output | NUM_EXC | Non-secure pending bits |
| pend_s_o | output | NUM_EXC | Secure pending bits |

## Verification
The hardest case to reach is a forced override: the vector that gets cleared is a different one from the vector that was asked for. On top of that, the outcome also depends on whether that other vector happens to be active. To reach it, the bench resets before every trial. It works out the vector the rules select, activates that vector in most trials (and leaves it idle in the rest), and sometimes activates a bystander vector so that the return-to-base result flips. The sweep covers every number, both security flags, both modes, five priorities, both fault-target values and both target-security settings.

// File: rtl/exc_deact_pkg.sv
package exc_deact_pkg;
   localparam int VEC_RESET = 1;
   localparam int VEC_NMI   = 2;
   localparam int VEC_HARD  = 3;

   typedef enum logic [1:0] {
      CMP_OK        = 2'd0,
      CMP_ILLEGAL   = 2'd1,
      CMP_NOTACTIVE = 2'd2,
      CMP_INVALID   = 2'd3
   } cmp_res_e;
endpackage

// File: rtl/exc_vec_pick.sv
module exc_vec_pick
   import exc_deact_pkg::*;
#(
   parameter int NUM_EXC = 16,
   parameter int EXC_W = 4,
   parameter int PRIO_W = 9,
   parameter logic [NUM_EXC-1:0] BANKED = '0
) (
   input  logic [EXC_W-1:0]  req_num,
   input  logic              req_sec,
   input  logic [PRIO_W-1:0] prio,
   input  logic              v8_mode,
   input  logic              fault_ns,
   input  logic [NUM_EXC-1:0] tgt_sec,
   output logic [EXC_W-1:0]  sel_num,
   output logic              sel_sec,
   output logic              num_ok,
   output logic              mismatch
);
   localparam logic [PRIO_W-1:0] PRIO_M1 = {PRIO_W{1'b1}};
   localparam logic [PRIO_W-1:0] PRIO_M2 = {{(PRIO_W-1){1'b1}}, 1'b0};
   localparam logic [PRIO_W-1:0] PRIO_M3 = {{(PRIO_W-2){1'b1}}, 2'b01};

   logic req_banked;

   always_comb begin
      num_ok     = (int'(req_num) > VEC_RESET) && (int'(req_num) < NUM_EXC);
      req_banked = num_ok && BANKED[req_num];
      mismatch   = num_ok && !req_banked && (tgt_sec[req_num] != req_sec);
      // default: requested vector in its bank
      sel_num = req_num;
      sel_sec = req_sec && req_banked;
      if (v8_mode) begin
         unique case (prio)
            PRIO_M1: begin
               sel_num = EXC_W'(VEC_HARD);
               sel_sec = !fault_ns;
            end
            PRIO_M2: begin
               sel_num = EXC_W'(VEC_NMI);
               sel_sec = 1'b0;
            end
            PRIO_M3: begin
               sel_num = EXC_W'(VEC_HARD);
               sel_sec = 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/exc_state_bank.sv
module exc_state_bank #(
   parameter int NUM_EXC = 16,
   parameter int EXC_W = 4,
   parameter logic [NUM_EXC-1:0] BANKED = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [EXC_W-1:0]   set_num,
   input  logic               set_sec,
   input  logic               clr_en,
   input  logic [EXC_W-1:0]   clr_num,
   input  logic               clr_sec,
   input  logic               repend,
   output logic [NUM_EXC-1:0] act_ns,
   output logic [NUM_EXC-1:0] act_s,
   output logic [NUM_EXC-1:0] pend_ns,
   output logic [NUM_EXC-1:0] pend_s
);
   for (genvar i = 0; i < NUM_EXC; i++) begin : g_vec
      logic set_hit_ns, clr_hit_ns;

      assign set_hit_ns = set_en && (set_num == EXC_W'(i)) && !(set_sec && BANKED[i]);
      assign clr_hit_ns = clr_en && (clr_num == EXC_W'(i)) && !clr_sec;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_ns[i]  <= 1'b0;
            pend_ns[i] <= 1'b0;
         end else if (clr_hit_ns) begin
            act_ns[i] <= 1'b0;
            if (repend) pend_ns[i] <= 1'b1;
         end else if (set_hit_ns) begin
            act_ns[i]  <= 1'b1;
            pend_ns[i] <= 1'b0;
         end
      end

      if (BANKED[i]) begin : g_sec
         logic set_hit_s, clr_hit_s;

         assign set_hit_s = set_en && (set_num == EXC_W'(i)) && set_sec;
         assign clr_hit_s = clr_en && (clr_num == EXC_W'(i)) && clr_sec;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               act_s[i]  <= 1'b0;
               pend_s[i] <= 1'b0;
            end else if (clr_hit_s) begin
               act_s[i] <= 1'b0;
               if (repend) pend_s[i] <= 1'b1;
            end else if (set_hit_s) begin
               act_s[i]  <= 1'b1;
               pend_s[i] <= 1'b0;
            end
         end
      end else begin : g_nosec
         assign act_s[i]  = 1'b0;
         assign pend_s[i] = 1'b0;
      end
   end
endmodule

// File: rtl/exc_deact_top.sv
module exc_deact_top
   import exc_deact_pkg::*;
#(
   parameter int NUM_EXC = 16,
   parameter int PRIO_W = 9,
   parameter logic [NUM_EXC-1:0] BANKED = NUM_EXC'(32'h0000_C878),
   localparam int EXC_W = $clog2(NUM_EXC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               act_req,
   input  logic [EXC_W-1:0]   act_num,
   input  logic               act_sec,
   input  logic               cmp_req,
   input  logic [EXC_W-1:0]   cmp_num,
   input  logic               cmp_sec,
   input  logic [PRIO_W-1:0]  exec_prio,
   input  logic               v8_mode,
   input  logic               fault_ns,
   input  logic [NUM_EXC-1:0] tgt_sec,
   input  logic [NUM_EXC-1:0] lvl_cfg,
   input  logic [NUM_EXC-1:0] line_in,
   output logic               cmp_done,
   output logic [EXC_W-1:0]   cmp_sel_num,
   output logic               cmp_sel_sec,
   output logic               cmp_fail,
   output logic               cmp_illegal,
   output logic               cmp_rettobase,
   output logic [NUM_EXC-1:0] act_ns_o,
   output logic [NUM_EXC-1:0] act_s_o,
   output logic [NUM_EXC-1:0] pend_ns_o,
   output logic [NUM_EXC-1:0] pend_s_o
);
   localparam logic [NUM_EXC-1:0] ONE_HOT0 = {{(NUM_EXC-1){1'b0}}, 1'b1};

   if (NUM_EXC < 4 || NUM_EXC > 512) begin : g_bad_num
      $error("NUM_EXC must lie in 4..512");
   end
   if (PRIO_W < 3) begin : g_bad_prio
      $error("PRIO_W must be at least 3");
   end

   logic [EXC_W-1:0] sel_num;
   logic             sel_sec, num_ok, mismatch, cur_active, do_clr, repend, set_ok;
   logic [NUM_EXC-1:0] clr_mask, after_ns, after_s;
   cmp_res_e         res;

   exc_vec_pick #(
      .NUM_EXC(NUM_EXC), .EXC_W(EXC_W), .PRIO_W(PRIO_W), .BANKED(BANKED)
   ) u_pick (
      .req_num (cmp_num),
      .req_sec (cmp_sec),
      .prio    (exec_prio),
      .v8_mode (v8_mode),
      .fault_ns(fault_ns),
      .tgt_sec (tgt_sec),
      .sel_num (sel_num),
      .sel_sec (sel_sec),
      .num_ok  (num_ok),
      .mismatch(mismatch)
   );

   always_comb begin
      cur_active = sel_sec ? act_s_o[sel_num] : act_ns_o[sel_num];
      if (!num_ok)          res = CMP_INVALID;
      else if (!cur_active) res = CMP_NOTACTIVE;
      else if (mismatch)    res = CMP_ILLEGAL;
      else                  res = CMP_OK;
      do_clr   = cmp_req && (res == CMP_OK || res == CMP_ILLEGAL);
      repend   = lvl_cfg[sel_num] && line_in[sel_num];
      clr_mask = do_clr ? (ONE_HOT0 << sel_num) : '0;
      after_ns = sel_sec ? act_ns_o : (act_ns_o & ~clr_mask);
      after_s  = sel_sec ? (act_s_o & ~clr_mask) : act_s_o;
      set_ok   = act_req && !cmp_req &&
                 (int'(act_num) > VEC_RESET) && (int'(act_num) < NUM_EXC);
   end

   exc_state_bank #(
      .NUM_EXC(NUM_EXC), .EXC_W(EXC_W), .BANKED(BANKED)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (set_ok),
      .set_num(act_num),
      .set_sec(act_sec),
      .clr_en (do_clr),
      .clr_num(sel_num),
      .clr_sec(sel_sec),
      .repend (repend),
      .act_ns (act_ns_o),
      .act_s  (act_s_o),
      .pend_ns(pend_ns_o),
      .pend_s (pend_s_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_done      <= 1'b0;
         cmp_sel_num   <= '0;
         cmp_sel_sec   <= 1'b0;
         cmp_fail      <= 1'b0;
         cmp_illegal   <= 1'b0;
         cmp_rettobase <= 1'b0;
      end else begin
         cmp_done <= cmp_req;
         if (cmp_req) begin
            cmp_sel_num   <= sel_num;
            cmp_sel_sec   <= sel_sec;
            cmp_fail      <= (res == CMP_INVALID) || (res == CMP_NOTACTIVE);
            cmp_illegal   <= (res == CMP_ILLEGAL);
            cmp_rettobase <= do_clr && ((after_ns | after_s) == '0);
         end
      end
   end
endmodule

// File: rtl/exc_deact_chk.sv
module exc_deact_chk #(
   parameter int NUM_EXC = 16,
   parameter int PRIO_W = 9,
   localparam int EXC_W = $clog2(NUM_EXC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmp_req,
   input logic [EXC_W-1:0]   cmp_num,
   input logic [PRIO_W-1:0]  exec_prio,
   input logic               v8_mode,
   input logic               cmp_done,
   input logic [EXC_W-1:0]   cmp_sel_num,
   input logic               cmp_sel_sec,
   input logic               cmp_fail,
   input logic               cmp_illegal,
   input logic               cmp_rettobase,
   input logic [NUM_EXC-1:0] act_ns_o,
   input logic [NUM_EXC-1:0] act_s_o,
   input logic [NUM_EXC-1:0] pend_ns_o,
   input logic [NUM_EXC-1:0] pend_s_o
);
   localparam logic [PRIO_W-1:0] PRIO_M2 = {{(PRIO_W-1){1'b1}}, 1'b0};

   logic [NUM_EXC-1:0] prv_ns, prv_s, prv_pns, prv_ps;
   logic req_ok;

   assign req_ok = (int'(cmp_num) > 1) && (int'(cmp_num) < NUM_EXC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prv_ns <= '0; prv_s <= '0; prv_pns <= '0; prv_ps <= '0;
      end else begin
         prv_ns <= act_ns_o; prv_s <= act_s_o; prv_pns <= pend_ns_o; prv_ps <= pend_s_o;
      end
   end

   // R2
   done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_req |=> cmp_done);
   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_req |=> !cmp_done);
   // R9
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_done && !cmp_fail) |->
         (cmp_sel_sec ? (prv_s[cmp_sel_num] && !act_s_o[cmp_sel_num])
                      : (prv_ns[cmp_sel_num] && !act_ns_o[cmp_sel_num])));
   // R3
   fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_done && cmp_fail) |->
         (act_ns_o == prv_ns && act_s_o == prv_s && pend_ns_o == prv_pns && pend_s_o == prv_ps));
   // R12
   base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_done && !cmp_fail) |-> (cmp_rettobase == ((act_ns_o | act_s_o) == '0)));
   // R6
   nmi_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_req && v8_mode && req_ok && exec_prio == PRIO_M2) |=>
         (int'(cmp_sel_num) == 2 && !cmp_sel_sec));
   // R4
   old_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_req && !v8_mode && req_ok) |=> (cmp_sel_num == $past(cmp_num)));
   // R10
   illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_illegal |-> !cmp_fail);
endmodule

bind exc_deact_top exc_deact_chk #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmp_req(cmp_req), .cmp_num(cmp_num),
   .exec_prio(exec_prio), .v8_mode(v8_mode), .cmp_done(cmp_done),
   .cmp_sel_num(cmp_sel_num), .cmp_sel_sec(cmp_sel_sec), .cmp_fail(cmp_fail),
   .cmp_illegal(cmp_illegal), .cmp_rettobase(cmp_rettobase),
   .act_ns_o(act_ns_o), .act_s_o(act_s_o), .pend_ns_o(pend_ns_o), .pend_s_o(pend_s_o)
);

// File: tb/exc_deact_top_test.sv
`timescale 1ns/1ps
module exc_deact_top_test;
   localparam int N = 12;
   localparam int PW = 9;
   localparam int EW = 4;
   localparam logic [N-1:0] BK  = 12'h878;
   localparam logic [N-1:0] LVL = 12'hAAA;

   logic clk = 1'b0, rst_n = 1'b0;
   logic act_req = 0, act_sec = 0, cmp_req = 0, cmp_sec = 0, v8_mode = 0, fault_ns = 0;
   logic [EW-1:0] act_num = '0, cmp_num = '0;
   logic [PW-1:0] exec_prio = '0;
   logic [N-1:0] tgt_sec = '0, lvl_cfg = '0, line_in = '0;
   logic cmp_done, cmp_sel_sec, cmp_fail, cmp_illegal, cmp_rettobase;
   logic [EW-1:0] cmp_sel_num;
   logic [N-1:0] act_ns_o, act_s_o, pend_ns_o, pend_s_o;

   exc_deact_top #(.NUM_EXC(N), .PRIO_W(PW), .BANKED(BK)) uut (.*);

   always #4 clk = ~clk;

   int total = 0, bad = 0;
   bit fin = 0;
   logic [N-1:0] m_ns, m_s, m_pns, m_ps;

   task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
      end
   endtask

   function automatic bit bk(input int k);
      return (k >= 0 && k < N) ? BK[k] : 1'b0;
   endfunction

   task automatic do_reset();
      @(negedge clk) rst_n = 0;
      @(negedge clk);
      @(negedge clk) rst_n = 1;
      m_ns = '0; m_s = '0; m_pns = '0; m_ps = '0;
   endtask

   task automatic activate(input int num, input bit sec);
      @(negedge clk);
      act_req = 1; act_num = EW'(num); act_sec = sec;
      @(negedge clk);
      act_req = 0;
      if (num > 1 && num < N) begin
         if (sec && bk(num)) begin m_s[num] = 1; m_ps[num] = 0; end
         else begin m_ns[num] = 1; m_pns[num] = 0; end
      end
   endtask

   task automatic state_chk(input string tag);
      chk(act_ns_o == m_ns, tag, 32'(act_ns_o), 32'(m_ns));
      chk(act_s_o == m_s, tag, 32'(act_s_o), 32'(m_s));
      chk(pend_ns_o == m_pns, tag, 32'(pend_ns_o), 32'(m_pns));
      chk(pend_s_o == m_ps, tag, 32'(pend_s_o), 32'(m_ps));
   endtask

   initial begin
      #(8 * 200000);
      if (!fin) begin
         total++; bad++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int pv[5] = '{-3, -2, -1, 0, 5};
      int it = 0;
      do_reset();
      // R1 reset state
      @(negedge clk);
      state_chk("R1");
      chk(!cmp_done && !cmp_fail && !cmp_illegal && !cmp_rettobase, "R1",
          {cmp_done, cmp_fail, cmp_illegal, cmp_rettobase}, 0);

      // R11 / R13 directed: re-pend then activation ignored during completion
      lvl_cfg = LVL; line_in = '1; tgt_sec = '0; exec_prio = '0; v8_mode = 0;
      activate(7, 0);
      @(negedge clk);
      cmp_req = 1; cmp_num = 4'd7; cmp_sec = 0;
      @(negedge clk);
      cmp_req = 0;
      m_ns[7] = 0; m_pns[7] = 1;
      state_chk("R11");
      chk(cmp_rettobase == 1, "R12", cmp_rettobase, 1);
      chk(cmp_done == 1, "R2", cmp_done, 1);
      @(negedge clk);
      chk(cmp_done == 0, "R2", cmp_done, 0);
      cmp_req = 1; cmp_num = 4'd9; act_req = 1; act_num = 4'd7; act_sec = 0;
      @(negedge clk);
      cmp_req = 0; act_req = 0;
      chk(cmp_fail == 1, "R9", cmp_fail, 1);
      state_chk("R13");
      activate(7, 0);
      state_chk("R13");

      // sweep
      for (int n = 0; n < 16; n++)
       for (int s = 0; s < 2; s++)
        for (int m = 0; m < 2; m++)
         for (int pi = 0; pi < 5; pi++)
          for (int f = 0; f < 2; f++)
           for (int ts = 0; ts < 2; ts++) begin
              int en; bit es, valid, fail_e, ill_e, act_e, lineh; string tg;
              do_reset();
              v8_mode = m[0]; fault_ns = f[0]; tgt_sec = ts[0] ? '1 : '0;
              exec_prio = PW'(pv[pi]); lvl_cfg = LVL;
              lineh = it[0]; line_in = lineh ? '1 : '0;
              valid = (n > 1 && n < N);
              en = n; es = s[0] && bk(n);
              if (m == 1 && pv[pi] == -1) begin en = 3; es = !f[0]; end
              else if (m == 1 && pv[pi] == -2) begin en = 2; es = 0; end
              else if (m == 1 && pv[pi] == -3) begin en = 3; es = 1; end
              if (m == 0) tg = "R4";
              else if (pv[pi] == -1) tg = "R5";
              else if (pv[pi] == -2) tg = "R6";
              else if (pv[pi] == -3) tg = "R7";
              else tg = "R8";
              if (valid && (it % 3 != 2)) activate(en, es);
              if (it % 4 == 0) activate(5, 0);
              act_e = es ? m_s[en] : m_ns[en];
              fail_e = !valid || !act_e;
              ill_e = !fail_e && !bk(n) && (ts[0] != s[0]);
              @(negedge clk);
              cmp_req = 1; cmp_num = EW'(n); cmp_sec = s[0];
              @(negedge clk);
              cmp_req = 0;
              if (!fail_e) begin
                 if (es) m_s[en] = 0; else m_ns[en] = 0;
                 if (LVL[en] && lineh) begin
                    if (es) m_ps[en] = 1; else m_pns[en] = 1;
                 end
              end
              chk(cmp_done == 1, "R2", cmp_done, 1);
              chk(cmp_fail == fail_e, valid ? "R9" : "R3", cmp_fail, fail_e);
              chk(cmp_illegal == ill_e, "R10", cmp_illegal, ill_e);
              if (valid) begin
                 chk(cmp_sel_num == EW'(en), tg, cmp_sel_num, en);
                 chk(cmp_sel_sec == es, tg, cmp_sel_sec, es);
              end
              if (!fail_e)
                 chk(cmp_rettobase == ((m_ns | m_s) == '0), "R12", cmp_rettobase,
                     ((m_ns | m_s) == '0));
              state_chk(fail_e ? "R3_R9" : "R11");
              it++;
           end

      fin = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule